// File: doc/BRIEF.md
# SPI Transaction Command Sequencer

This block runs one SPI transaction per command word. A command picks one of four chip selects, gives the total number of bytes to shift (1 to 65536), and may give a count of leading bytes whose received data is thrown away. Two flags complete the command. One suppresses all receive data. The other switches reception to two data lines once the leading bytes are done. The whole transaction runs under a single chip-select assertion, so one command can cover a message made of several parts, such as an opcode and address followed by a read.

The sequencer sits between a transmit FIFO, a byte-level shift engine and a receive FIFO. It passes one byte to the engine at a time and waits for the engine to report that the byte is finished. It writes each received byte that is wanted into the receive FIFO. After the last byte it raises a one-cycle done event and then releases the chip select. The FIFO storage and the bit clocking are outside this block.

Top module: `spi_cmd_sequencer`

## Requirements
- R1: The command word is read as follows: chip select in bits 31:30, dual-line read flag in bit 28, TX-only flag in bit 27, skip count in bits 26:16, and transaction length minus one in bits 15:0. A command is accepted only when the block is idle. In the cycle after acceptance, the selected active-low chip select (cs_n bit i for select value i) goes low, and at most one chip select is low at any time.
- R2: A transaction shifts exactly length-field + 1 bytes. The field value 0xFFFF gives 65536 bytes.
- R3: With a skip count of 0, every byte pops one TX FIFO entry and sends it unchanged. Each byte the engine returns is pushed to the RX FIFO with its value, unless TX-only is set.
- R4: With a skip count N > 0, bytes 0..N-1 are taken from the TX FIFO and their received data is discarded. Every later byte is sent as 0x00 without popping the TX FIFO, and its received data is pushed. If N is at least the length, no byte is pushed.
- R5: The dual-line indication goes with each byte after the skip phase when the dual flag is set. With a skip count of 0, the dual flag has no effect and the indication stays low.
- R6: With TX-only set, nothing is pushed to the RX FIFO.
- R7: When a byte needs TX data and the TX FIFO is empty, no byte is started and nothing is popped. The chip select stays asserted, and the sequence resumes as soon as data is present.
- R8: Done is high for exactly one cycle, the cycle after the engine finishes the last byte. The chip select is released, and busy drops, in the following cycle.
- R9: A command presented while busy is high has no effect: the running transaction, its chip select and its byte count are unchanged. This includes a command presented in the done cycle.
- R10: In reset, all chip selects are high and busy, byte start, TX pop, RX push and done are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 32 | Command word |
| busy | output | 1 | Transaction in progress |
| cs_n | output | NUM_CS | Active-low chip selects |
| tx_empty | input | 1 | TX FIFO has no data |
| tx_data | input | BYTE_W | TX FIFO head byte |
| tx_pop | output | 1 | Remove TX FIFO head |
| eng_go | output | 1 | Start shifting one byte |
| eng_byte | output | BYTE_W | Byte to shift out |
| eng_dual | output | 1 | Receive this byte on two lines |
| eng_done | input | 1 | Engine finished current byte |
| eng_rx | input | BYTE_W | Byte received by engine |
| rx_push | output | 1 | Write RX FIFO |
| rx_data | output | BYTE_W | Byte written to RX FIFO |
| done | output | 1 | One-cycle transaction-complete event |

## Verification
The two events most likely to interfere are the done cycle and the arrival of a new command. In that cycle the block is still busy but is about to return to idle. The bench waits until it sees done and then presents a fresh command, so the command is sampled on exactly that edge. The reference model, which accepts commands only from idle, expects the command to be dropped. The bench then checks that no new chip select goes low, no byte starts and busy stays low. A command presented in the middle of a transfer is handled the same way, and the bench judges it by the chip select staying on the original target.

// File: rtl/sqc_pkg.sv
package sqc_pkg;
  localparam int CMD_W  = 32;
  localparam int SEL_W  = 2;
  localparam int LEN_W  = 16;
  localparam int SKIP_W = 11;

  localparam int SEL_HI  = 31;
  localparam int DUAL_B  = 28;
  localparam int TXO_B   = 27;
  localparam int SKIP_LO = 16;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2,
    SQ_DONE  = 2'd3
  } sq_state_t;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic              dual;
    logic              txonly;
    logic [SKIP_W-1:0] skip;
    logic [LEN_W-1:0]  last;
  } sq_cmd_t;

  function automatic sq_cmd_t cmd_unpack(input logic [CMD_W-1:0] w);
    sq_cmd_t c;
    c.sel    = w[SEL_HI -: SEL_W];
    c.dual   = w[DUAL_B];
    c.txonly = w[TXO_B];
    c.skip   = w[SKIP_LO +: SKIP_W];
    c.last   = w[LEN_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/sqc_cmd_reg.sv
module sqc_cmd_reg
  import sqc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  sq_cmd_t cmd_d,
  output sq_cmd_t cmd_q
);
  sq_cmd_t cmd_nx;

  always_comb begin
    cmd_nx = cmd_q;
    if (load) cmd_nx = cmd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_nx;
  end
endmodule

// File: rtl/sqc_byte_ctr.sv
module sqc_byte_ctr
  import sqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic [LEN_W-1:0]  last,
  input  logic [SKIP_W-1:0] skip,
  output logic              is_last,
  output logic              in_skip,
  output logic              post_skip
);
  localparam int PAD_W = LEN_W - SKIP_W;

  logic [LEN_W-1:0] idx_q, idx_nx;
  logic [LEN_W-1:0] skip_ext;
  logic             skip_on;

  assign skip_ext  = {{PAD_W{1'b0}}, skip};
  assign skip_on   = |skip;
  assign is_last   = (idx_q == last);
  assign in_skip   = skip_on && (idx_q <  skip_ext);
  assign post_skip = skip_on && (idx_q >= skip_ext);

  always_comb begin
    idx_nx = idx_q;
    if (clear)        idx_nx = '0;
    else if (advance) idx_nx = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_nx;
  end
endmodule

// File: rtl/sqc_cs_drv.sv
module sqc_cs_drv
  import sqc_pkg::*;
#(
  parameter int NUM_CS = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_nx,
  input  logic [SEL_W-1:0]  sel_nx,
  output logic [NUM_CS-1:0] cs_n
);
  logic [NUM_CS-1:0] cs_n_nx;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_comb cs_n_nx[i] = !(active_nx && (sel_nx == SEL_W'(i)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_n[i] <= 1'b1;
      else        cs_n[i] <= cs_n_nx[i];
    end
  end

  // R1
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
endmodule

// File: rtl/spi_cmd_sequencer.sv
module spi_cmd_sequencer
  import sqc_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int BYTE_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              busy,
  output logic [NUM_CS-1:0] cs_n,
  input  logic              tx_empty,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              eng_go,
  output logic [BYTE_W-1:0] eng_byte,
  output logic              eng_dual,
  input  logic              eng_done,
  input  logic [BYTE_W-1:0] eng_rx,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_data,
  output logic              done
);
  sq_state_t        st_q, st_nx;
  sq_cmd_t          cmd_in, cmd_q;
  logic             accept, need_tx, byte_end;
  logic             is_last, in_skip, post_skip;
  logic [SEL_W-1:0] sel_nx;

  assign cmd_in   = cmd_unpack(cmd_word);
  assign accept   = (st_q == SQ_IDLE) && cmd_valid;
  assign byte_end = (st_q == SQ_WAIT) && eng_done;
  assign need_tx  = !post_skip;

  sqc_cmd_reg u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .cmd_d (cmd_in),
    .cmd_q (cmd_q)
  );

  sqc_byte_ctr u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .advance   (byte_end && !is_last),
    .last      (cmd_q.last),
    .skip      (cmd_q.skip),
    .is_last   (is_last),
    .in_skip   (in_skip),
    .post_skip (post_skip)
  );

  always_comb begin
    eng_go   = (st_q == SQ_ISSUE) && (!need_tx || !tx_empty);
    tx_pop   = eng_go && need_tx;
    eng_byte = need_tx ? tx_data : '0;
    eng_dual = post_skip && cmd_q.dual;
    rx_push  = byte_end && !cmd_q.txonly && !in_skip;
    rx_data  = eng_rx;
    busy     = (st_q != SQ_IDLE);
    done     = (st_q == SQ_DONE);
  end

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      SQ_IDLE:  if (cmd_valid) st_nx = SQ_ISSUE;
      SQ_ISSUE: if (eng_go)    st_nx = SQ_WAIT;
      SQ_WAIT:  if (eng_done)  st_nx = is_last ? SQ_DONE : SQ_ISSUE;
      SQ_DONE:                 st_nx = SQ_IDLE;
      default:                 st_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_nx;
  end

  assign sel_nx = accept ? cmd_in.sel : cmd_q.sel;

  sqc_cs_drv #(.NUM_CS(NUM_CS)) u_cs (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_nx (st_nx != SQ_IDLE),
    .sel_nx    (sel_nx),
    .cs_n      (cs_n)
  );

  // R7
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  // R3
  one_byte_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> !eng_go);

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (&cs_n && !busy && !done));

  // R5
  dual_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_go && eng_dual) |-> !tx_pop);

  // R9
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && cmd_valid) |=> $stable(cs_n));
endmodule

// File: tb/tb_spi_cmd_sequencer.sv
module tb_spi_cmd_sequencer;
  localparam int NUM_CS = 4;
  localparam int BW     = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [31:0]   cmd_word = '0;
  logic          busy;
  logic [3:0]    cs_n;
  logic          tx_empty = 1'b1;
  logic [BW-1:0] tx_data = '0;
  logic          tx_pop, eng_go, eng_dual, rx_push, done;
  logic [BW-1:0] eng_byte, rx_data;
  logic          eng_done = 1'b0;
  logic [BW-1:0] eng_rx = '0;

  spi_cmd_sequencer #(.NUM_CS(NUM_CS), .BYTE_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .busy(busy), .cs_n(cs_n), .tx_empty(tx_empty), .tx_data(tx_data),
    .tx_pop(tx_pop), .eng_go(eng_go), .eng_byte(eng_byte), .eng_dual(eng_dual),
    .eng_done(eng_done), .eng_rx(eng_rx), .rx_push(rx_push), .rx_data(rx_data),
    .done(done)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // stimulus requests from the script
  logic          req_valid = 1'b0;
  logic [31:0]   req_word  = '0;
  logic [BW-1:0] tx_q[$];
  bit            fast = 0;

  // bench-side engine and counters
  bit   e_busy = 0;
  int   e_cnt = 0;
  int   e_val = 0;
  int   rx_seed = 17;
  int   go_count = 0;
  int   rx_count = 0;

  // reference model state
  int m_st = 0, m_cs = 0, m_last = 0, m_skip = 0, m_txo = 0, m_dual = 0, m_idx = 0;

  always begin
    @(negedge clk);
    cmd_valid = req_valid;
    cmd_word  = req_word;
    tx_empty  = (tx_q.size() == 0);
    tx_data   = (tx_q.size() == 0) ? '0 : tx_q[0];
    if (e_busy) begin
      if (e_cnt <= 1) begin
        eng_done = 1'b1;
        eng_rx   = BW'(e_val);
        e_busy   = 0;
      end else begin
        e_cnt--;
        eng_done = 1'b0;
      end
    end else begin
      eng_done = 1'b0;
    end
    #3;
    if (!rst_n) begin
      m_st = 0;
      chk(cs_n == 4'hF, "R10 cs_n in reset", cs_n, 4'hF);
      chk({busy, eng_go, tx_pop, rx_push, done} == 5'b0, "R10 outputs in reset",
          {busy, eng_go, tx_pop, rx_push, done}, 0);
    end else begin
      bit post, inskip, need, e_go, e_push;
      logic [3:0] e_cs;
      post   = (m_skip != 0) && (m_idx >= m_skip);
      inskip = (m_skip != 0) && (m_idx <  m_skip);
      need   = !post;
      e_go   = (m_st == 1) && (!need || !tx_empty);
      e_push = (m_st == 2) && eng_done && (m_txo == 0) && !inskip;
      e_cs   = (m_st == 0) ? 4'hF : ~(4'b0001 << m_cs);
      chk(cs_n == e_cs, "R1 cs_n", cs_n, e_cs);
      chk(busy == (m_st != 0), "R9 busy", busy, m_st != 0);
      chk(eng_go == e_go, "R7 eng_go", eng_go, e_go);
      chk(tx_pop == (e_go && need), "R3 tx_pop", tx_pop, e_go && need);
      if (e_go) begin
        chk(eng_byte == (need ? tx_data : 8'h00), "R4 eng_byte", eng_byte, need ? tx_data : 8'h00);
        chk(eng_dual == (post && m_dual != 0), "R5 eng_dual", eng_dual, post && m_dual != 0);
      end
      chk(rx_push == e_push, "R6 rx_push", rx_push, e_push);
      if (e_push) chk(rx_data == eng_rx, "R3 rx_data", rx_data, eng_rx);
      chk(done == (m_st == 3), "R8 done", done, m_st == 3);
      // model step for the coming edge
      case (m_st)
        0: if (cmd_valid) begin
             m_cs = cmd_word[31:30]; m_dual = cmd_word[28]; m_txo = cmd_word[27];
             m_skip = cmd_word[26:16]; m_last = cmd_word[15:0]; m_idx = 0; m_st = 1;
           end
        1: if (e_go) m_st = 2;
        2: if (eng_done) begin
             if (m_idx == m_last) m_st = 3;
             else begin m_idx++; m_st = 1; end
           end
        default: m_st = 0;
      endcase
      if (tx_pop && tx_q.size() > 0) void'(tx_q.pop_front());
      if (rx_push) rx_count++;
      if (eng_go) begin
        e_busy = 1;
        e_cnt  = fast ? 1 : 1 + (go_count % 3);
        e_val  = rx_seed & 255;
        rx_seed = (rx_seed * 5 + 3) & 255;
        go_count++;
      end
    end
  end

  task automatic send_cmd(input int cs, input int dual, input int txo, input int skip, input int len);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_word  = {cs[1:0], 1'b0, dual[0], txo[0], skip[10:0], 16'(len - 1)};
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(posedge clk);
    while (busy) @(posedge clk);
    #1;
  endtask

  task automatic push_bytes(input int n, input int base);
    for (int i = 0; i < n; i++) tx_q.push_back(BW'(base + i * 7));
  endtask

  int go0, rx0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(busy == 1'b0, "R10 idle after reset", busy, 0);
    chk(cs_n == 4'hF, "R10 cs_n after reset", cs_n, 4'hF);

    // normal read/write, chip select 1
    push_bytes(5, 8'h11);
    rx0 = rx_count;
    send_cmd(1, 0, 0, 0, 5);
    wait_idle();
    chk(rx_count - rx0 == 5, "R3 bytes received", rx_count - rx0, 5);

    // TX-only, chip select 2
    push_bytes(3, 8'h40);
    rx0 = rx_count;
    send_cmd(2, 0, 1, 0, 3);
    wait_idle();
    chk(rx_count - rx0 == 0, "R6 nothing pushed", rx_count - rx0, 0);

    // skip mode, chip select 3
    push_bytes(3, 8'h90);
    rx0 = rx_count;
    send_cmd(3, 0, 0, 3, 8);
    wait_idle();
    chk(rx_count - rx0 == 5, "R4 received after skip", rx_count - rx0, 5);
    chk(tx_q.size() == 0, "R4 only skip bytes popped", tx_q.size(), 0);

    // skip plus dual-line read
    push_bytes(2, 8'hA0);
    send_cmd(0, 1, 0, 2, 6);
    wait_idle();

    // dual flag without skip
    push_bytes(4, 8'h05);
    send_cmd(0, 1, 0, 0, 4);
    wait_idle();

    // stall on empty TX FIFO
    go0 = go_count;
    send_cmd(1, 0, 0, 0, 4);
    repeat (6) @(posedge clk); #1;
    chk(cs_n == 4'b1101, "R7 cs held during stall", cs_n, 4'b1101);
    chk(go_count == go0, "R7 no byte started", go_count - go0, 0);
    push_bytes(4, 8'h33);
    wait_idle();
    chk(go_count - go0 == 4, "R7 resumed", go_count - go0, 4);

    // command while busy, and in the done cycle
    push_bytes(6, 8'h70);
    go0 = go_count;
    send_cmd(2, 0, 0, 0, 6);
    repeat (3) @(posedge clk);
    send_cmd(0, 0, 0, 0, 2);
    chk(cs_n == 4'b1011, "R9 cs unchanged by busy command", cs_n, 4'b1011);
    do begin @(posedge clk); #1; end while (!done);
    req_valid = 1'b1;
    req_word  = {2'd1, 1'b0, 1'b0, 1'b0, 11'd0, 16'd1};
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (4) @(posedge clk); #1;
    chk(busy == 1'b0, "R9 done-cycle command dropped", busy, 0);
    chk(cs_n == 4'hF, "R9 no new select", cs_n, 4'hF);
    chk(go_count - go0 == 6, "R9 byte count kept", go_count - go0, 6);

    // skip count beyond length
    push_bytes(3, 8'hC0);
    rx0 = rx_count;
    send_cmd(1, 0, 0, 5, 3);
    wait_idle();
    chk(rx_count - rx0 == 0, "R4 skip covers all", rx_count - rx0, 0);

    // maximum length
    fast = 1;
    push_bytes(1, 8'hEE);
    go0 = go_count;
    send_cmd(3, 0, 1, 1, 65536);
    wait_idle();
    chk(go_count - go0 == 65536, "R2 max length", go_count - go0, 65536);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000 && !finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule